// File: doc/BRIEF.md
# Serial NOR Flash Device Emulator

A synthesizable model of a serial NOR flash device, used on the far side of a flash controller so that the controller can be tested without a real part. The model watches chip select, the serial clock and four data lines. It decodes a subset of commands and keeps its contents in a small internal byte array. The supported commands are status read, identifier read, write enable and disable, status write, single-wire read, a four-wire read with address, mode and dummy cycles, single-wire and four-wire page program, and sector erase. Its output lines follow the width of the current command's data phase.

All timing runs on the system clock `clk`. The serial clock and chip select are sampled there, so `clk` must run several times faster than the serial clock. Input bits are taken on a rising serial clock edge and the output changes after a falling edge (clock mode 0). After a program, erase or status write, the busy bit is set for a short time set by a parameter. An erase also walks the sector one byte per clock before that time starts. When the operation finishes, the write-enable latch clears.

The array has `2^MEM_AW` bytes and sectors have `2^SECTOR_AW` bytes. Address bits above the array width are ignored. A full-size sector is 64 KiB (`SECTOR_AW = 16`); the defaults are small so that the whole array can be swept.

Top module: `spi_nor_emu`

## Requirements
- R1: After reset the status byte reads 0x1C. Bit 0 is busy, bit 1 is the write-enable latch and bits 7:2 hold the stored value 0b000111. Status read (0x05) repeats the live status byte for as long as chip select stays low.
- R2: Identifier read (0x9F) returns the four bytes of `DEVICE_ID` (default 0x5A173CE1), most significant byte first, and then repeats them.
- R3: Write enable (0x06) sets status bit 1 and write disable (0x04) clears it.
- R4: Page program, sector erase and status write have no effect, and never set busy, unless the write-enable latch was set by an earlier chip-select frame.
- R5: Page program (0x02) takes a 24-bit address, most significant byte first, followed by data bytes on dq[0]. Each byte stores old AND data. The address wraps inside the 256-byte page.
- R6: Quad page program (0x32) takes its address on dq[0]. Each data byte then arrives as two 4-bit clocks on dq[3:0], high nibble first.
- R7: Sector erase (0xD8) sets every byte of the sector that holds the address to 0xFF; the sector base is the address with its low `SECTOR_AW` bits cleared. Bytes outside that sector are unchanged.
- R8: While a program, erase or status write is in progress, status bit 0 reads 1 and every command except 0x05 is ignored. When the operation ends, busy and the write-enable latch both read 0.
- R9: Read (0x03) takes a 24-bit address on dq[0]. Data then comes out on dq[1], most significant bit first, from consecutive addresses.
- R10: Quad I/O read (0xEB) takes the address as 6 four-bit clocks, then a mode byte as 2 clocks, then 4 dummy clocks. Data bytes then come out on dq[3:0], high nibble first.
- R11: A mode byte of 0xA0 enters continuous read. The next frame then starts directly with the address phase and has no opcode. Any other mode byte leaves continuous read.
- R12: A command whose address or data byte is cut short by chip select rising changes neither the memory nor busy.
- R13: dq_oe is 0 outside a data-output phase. It is 4'b0010 for single-wire output and 4'b1111 for four-wire output. dq_out changes only after a falling serial clock edge, and dq_oe goes to 0 when chip select rises.
- R14: Status write (0x01) with the write-enable latch set stores bits 7:2 of its data byte; bits 1:0 stay busy and write-enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| dq_in | input | 4 | Data lines as driven by the controller |
| dq_out | output | 4 | Data lines as driven by the device |
| dq_oe | output | 4 | Per-line output enable of the device |

## Verification
A falling serial clock is seen at the first `clk` edge after it happens, so a new output bit is valid one system cycle after the fall. The bench holds the serial clock low for two cycles and samples `dq_out` just before the rising edge. A rising edge takes effect one cycle after it is driven, so an opcode or address is decoded by the time the next bit begins. Busy starts at the clock edge that sees chip select rise and lasts `BUSY_CYCLES`, plus one cycle per sector byte for an erase. The bench therefore checks busy in the first status frame after the operation starts, polls until busy clears, and only then checks the final status and the memory contents.

// File: rtl/spi_nor_emu.sv
module spi_nor_emu #(
  parameter int MEM_AW = 11,
  parameter int SECTOR_AW = 9,
  parameter int BUSY_CYCLES = 64,
  parameter logic [31:0] DEVICE_ID = 32'h5A173CE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] dq_in,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe
);
  localparam int MEM_BYTES = 1 << MEM_AW;
  localparam int SECT_BITS = MEM_AW - SECTOR_AW;
  localparam int PG_BITS = MEM_AW - 8;
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_MODE, S_DUMMY, S_DIN, S_DOUT} st_t;
  typedef enum logic [1:0] {SRC_STAT, SRC_ID, SRC_MEM} src_t;

  logic [7:0] mem [MEM_BYTES];

  st_t st;
  src_t src;
  logic sck_d, cs_d, qd, live, cont, wel, erasing, pend_wr, pend_er;
  logic [7:0] op, sh_out;
  logic [4:0] cnt;
  logic [2:0] ocnt;
  logic [23:0] sh;
  logic [5:0] sr_hi;
  logic [MEM_AW-1:0] rd_addr;
  logic [PG_BITS-1:0] pg_base;
  logic [7:0] pg_off;
  logic [SECT_BITS-1:0] esect;
  logic [SECTOR_AW-1:0] eptr;
  logic [BW-1:0] bcnt;

  logic busy, rise, fall, done_ph, mem_we;
  logic [4:0] plen;
  logic [23:0] sh_nx;
  logic [7:0] status, out_byte, id_byte, mem_wd;
  logic [MEM_AW-1:0] mem_wa;

  assign busy = erasing || (bcnt != '0);
  assign status = {sr_hi, wel, busy};
  assign rise = !cs_n && sck && !sck_d;
  assign fall = !cs_n && !sck && sck_d;
  assign sh_nx = qd ? {sh[19:0], dq_in} : {sh[22:0], dq_in[0]};

  always_comb begin
    case (st)
      S_CMD:   plen = 5'd8;
      S_ADDR:  plen = qd ? 5'd6 : 5'd24;
      S_MODE:  plen = 5'd2;
      S_DUMMY: plen = 5'd4;
      S_DIN:   plen = qd ? 5'd2 : 5'd8;
      default: plen = 5'd0;
    endcase
  end
  assign done_ph = (plen != 5'd0) && (cnt == plen - 5'd1);

  always_comb begin
    case (rd_addr[1:0])
      2'd0: id_byte = DEVICE_ID[31:24];
      2'd1: id_byte = DEVICE_ID[23:16];
      2'd2: id_byte = DEVICE_ID[15:8];
      default: id_byte = DEVICE_ID[7:0];
    endcase
  end
  assign out_byte = (src == SRC_STAT) ? status : (src == SRC_ID) ? id_byte : mem[rd_addr];

  assign mem_wa = erasing ? {esect, eptr} : {pg_base, pg_off};
  assign mem_we = erasing || (rise && st == S_DIN && done_ph && op != 8'h01);
  assign mem_wd = erasing ? 8'hFF : (mem[mem_wa] & sh_nx[7:0]);

  always_ff @(posedge clk)
    if (mem_we) mem[mem_wa] <= mem_wd;

  assign dq_out = !live ? 4'h0 : qd ? sh_out[7:4] : {2'b00, sh_out[7], 1'b0};
  assign dq_oe  = !live ? 4'h0 : qd ? 4'hF : 4'b0010;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; src <= SRC_STAT;
      sck_d <= 1'b0; cs_d <= 1'b1; qd <= 1'b0; live <= 1'b0; cont <= 1'b0;
      wel <= 1'b0; erasing <= 1'b0; pend_wr <= 1'b0; pend_er <= 1'b0;
      op <= '0; sh_out <= '0; cnt <= '0; ocnt <= '0; sh <= '0;
      sr_hi <= 6'b000111; rd_addr <= '0; pg_base <= '0; pg_off <= '0;
      esect <= '0; eptr <= '0; bcnt <= '0;
    end else begin
      sck_d <= sck;
      cs_d <= cs_n;
      if (erasing) begin
        eptr <= eptr + 1'b1;
        if (&eptr) begin
          erasing <= 1'b0;
          bcnt <= BW'(BUSY_CYCLES);
        end
      end else if (bcnt != '0) begin
        bcnt <= bcnt - 1'b1;
        if (bcnt == BW'(1)) wel <= 1'b0;
      end

      if (cs_n) begin
        st <= S_IDLE;
        live <= 1'b0;
        pend_wr <= 1'b0;
        pend_er <= 1'b0;
        if (!cs_d) begin
          if (pend_wr) bcnt <= BW'(BUSY_CYCLES);
          if (pend_er) begin
            erasing <= 1'b1;
            eptr <= '0;
          end
        end
      end else if (cs_d) begin
        cnt <= '0;
        live <= 1'b0;
        if (cont) begin
          st <= S_ADDR; op <= 8'hEB; qd <= 1'b1;
        end else begin
          st <= S_CMD; qd <= 1'b0;
        end
      end else if (rise) begin
        sh <= sh_nx;
        cnt <= cnt + 1'b1;
        if (done_ph) begin
          cnt <= '0;
          case (st)
            S_CMD: begin
              op <= sh_nx[7:0];
              st <= S_IDLE;
              if (!busy || sh_nx[7:0] == 8'h05) begin
                case (sh_nx[7:0])
                  8'h06: wel <= 1'b1;
                  8'h04: wel <= 1'b0;
                  8'h05: begin st <= S_DOUT; src <= SRC_STAT; ocnt <= '0; end
                  8'h9F: begin st <= S_DOUT; src <= SRC_ID; ocnt <= '0; rd_addr <= '0; end
                  8'h03: st <= S_ADDR;
                  8'hEB: begin st <= S_ADDR; qd <= 1'b1; end
                  8'h02, 8'h32, 8'hD8: if (wel) st <= S_ADDR;
                  8'h01: if (wel) st <= S_DIN;
                  default: st <= S_IDLE;
                endcase
              end
            end
            S_ADDR: begin
              rd_addr <= sh_nx[MEM_AW-1:0];
              pg_base <= sh_nx[MEM_AW-1:8];
              pg_off <= sh_nx[7:0];
              case (op)
                8'h03: begin st <= S_DOUT; src <= SRC_MEM; ocnt <= '0; end
                8'hEB: st <= S_MODE;
                8'h02: begin st <= S_DIN; qd <= 1'b0; end
                8'h32: begin st <= S_DIN; qd <= 1'b1; end
                8'hD8: begin
                  st <= S_IDLE;
                  pend_er <= 1'b1;
                  esect <= sh_nx[MEM_AW-1:SECTOR_AW];
                end
                default: st <= S_IDLE;
              endcase
            end
            S_MODE: begin
              cont <= (sh_nx[7:0] == 8'hA0);
              st <= S_DUMMY;
            end
            S_DUMMY: begin
              st <= S_DOUT; src <= SRC_MEM; ocnt <= '0;
            end
            S_DIN: begin
              pend_wr <= 1'b1;
              if (op == 8'h01) begin
                sr_hi <= sh_nx[7:2];
                st <= S_IDLE;
              end else begin
                pg_off <= pg_off + 1'b1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end else if (fall && st == S_DOUT) begin
        live <= 1'b1;
        if (ocnt == '0) begin
          sh_out <= out_byte;
          rd_addr <= rd_addr + 1'b1;
          ocnt <= qd ? 3'd1 : 3'd7;
        end else begin
          sh_out <= qd ? {sh_out[3:0], 4'h0} : {sh_out[6:0], 1'b0};
          ocnt <= ocnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_nor_emu_chk.sv
module spi_nor_emu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] dq_out,
  input logic [3:0] dq_oe,
  input logic       busy,
  input logic       wel
);
  logic sck_q;
  logic fall_now;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_q <= 1'b0;
    else sck_q <= sck;

  assign fall_now = sck_q && !sck;

  assert_oe_shape_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'h0) || (dq_oe == 4'b0010) || (dq_oe == 4'hF));

  assert_release_on_cs_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (dq_oe == 4'h0));

  assert_change_after_fall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cs_n) && !$stable(dq_out)) |-> $past(fall_now));

  assert_busy_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel);

  assert_wel_clears_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
endmodule

bind spi_nor_emu spi_nor_emu_chk i_chk (.*);

// File: tb/test_spi_nor_emu.sv
module test_spi_nor_emu;
  localparam int CLK_PERIOD = 10;
  localparam int MEMB = 2048;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck;
  logic [3:0] dq_in;
  logic [3:0] dq_out, dq_oe;
  logic [7:0] model [0:MEMB-1];
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_nor_emu i_spi_nor_emu (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 31 + i * 57 + ((i * i) >> 1));
  endfunction

  task automatic bit_x(input logic [3:0] d, output logic [3:0] q, output logic [3:0] oe);
    @(negedge clk); sck = 1'b0; dq_in = d;
    @(negedge clk); @(negedge clk);
    q = dq_out; oe = dq_oe;
    sck = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] b, output logic [7:0] r, output logic [3:0] oe);
    logic [3:0] q, o;
    for (int i = 7; i >= 0; i--) begin
      bit_x({3'b000, b[i]}, q, o);
      r[i] = q[1];
      if (i == 7) oe = o;
    end
  endtask

  task automatic qbyte(input logic [7:0] b, output logic [7:0] r, output logic [3:0] oe);
    logic [3:0] q, o;
    bit_x(b[7:4], q, oe); r[7:4] = q;
    bit_x(b[3:0], q, o); r[3:0] = q;
  endtask

  task automatic fstart();
    @(negedge clk); sck = 1'b0; cs_n = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic fend();
    @(negedge clk); sck = 1'b0;
    @(negedge clk); @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r; logic [3:0] o;
    fstart(); sbyte(op, r, o); fend();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] r; logic [3:0] o;
    fstart(); sbyte(8'h05, r, o); sbyte(8'h00, s, o); fend();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int k;
    s = 8'h01; k = 0;
    while (s[0] && k < 200) begin rd_status(s); k++; end
    if (s[0]) chk("R8 busy never cleared", 1, 0);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] r; logic [3:0] o;
    sbyte(a[23:16], r, o); sbyte(a[15:8], r, o); sbyte(a[7:0], r, o);
  endtask

  task automatic prog(input logic [23:0] a, input int n, input int seed, input bit quad, input bit eff);
    logic [7:0] r, d; logic [3:0] o;
    fstart();
    sbyte(quad ? 8'h32 : 8'h02, r, o);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      d = pat(seed, i);
      if (quad) qbyte(d, r, o); else sbyte(d, r, o);
      if (eff) model[(int'(a) & 'h700) | ((int'(a) + i) & 'hFF)] &= d;
    end
    fend();
  endtask

  task automatic erase(input logic [23:0] a, input int nb);
    logic [7:0] r; logic [3:0] o;
    fstart();
    sbyte(8'hD8, r, o);
    sbyte(a[23:16], r, o); sbyte(a[15:8], r, o);
    if (nb == 3) sbyte(a[7:0], r, o);
    fend();
  endtask

  task automatic sread(input int a, input int n, input string tag);
    logic [7:0] r; logic [3:0] o;
    fstart();
    sbyte(8'h03, r, o);
    chk("R13 no drive during opcode", 32'(o), 0);
    send_addr(24'(a));
    for (int i = 0; i < n; i++) begin
      sbyte(8'h00, r, o);
      chk(tag, 32'(r), 32'(model[(a + i) % MEMB]));
      if (i == 0) chk("R13 single output enable", 32'(o), 32'h2);
    end
    fend();
  endtask

  task automatic qread(input int a, input logic [7:0] mode, input bit skip, input int n, input string tag);
    logic [7:0] r; logic [3:0] q, o;
    fstart();
    if (!skip) sbyte(8'hEB, r, o);
    for (int k = 5; k >= 0; k--) begin
      bit_x(4'((a >> (4 * k)) & 'hF), q, o);
      if (k == 0) chk("R13 no drive during address", 32'(o), 0);
    end
    bit_x(mode[7:4], q, o); bit_x(mode[3:0], q, o);
    repeat (4) bit_x(4'h0, q, o);
    for (int i = 0; i < n; i++) begin
      qbyte(8'h00, r, o);
      chk(tag, 32'(r), 32'(model[(a + i) % MEMB]));
      if (i == 0) chk("R13 quad output enable", 32'(o), 32'hF);
    end
    fend();
  endtask

  initial begin
    logic [7:0] r, s;
    logic [3:0] o, q;
    cs_n = 1'b1; sck = 1'b0; dq_in = 4'h0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    fstart();
    sbyte(8'h05, r, o);
    chk("R13 no drive during status opcode", 32'(o), 0);
    sbyte(8'h00, r, o); chk("R1 status after reset", 32'(r), 32'h1C);
    chk("R13 single enable on status", 32'(o), 32'h2);
    sbyte(8'h00, r, o); chk("R1 status repeats", 32'(r), 32'h1C);
    fend();

    fstart();
    sbyte(8'h9F, r, o);
    for (int i = 0; i < 5; i++) begin
      sbyte(8'h00, r, o);
      chk("R2 identifier byte", 32'(r), 32'((32'h5A173CE1 >> (8 * (3 - (i % 4)))) & 'hFF));
    end
    fend();

    cmd1(8'h06); rd_status(s); chk("R3 write enable sets bit 1", 32'(s), 32'h1E);
    cmd1(8'h04); rd_status(s); chk("R3 write disable clears bit 1", 32'(s), 32'h1C);

    for (int sct = 0; sct < 4; sct++) begin
      cmd1(8'h06);
      erase(24'(sct << 9), 3);
      if (sct == 0) begin
        rd_status(s); chk("R8 busy during erase", 32'(s), 32'h1F);
        cmd1(8'h04);
        rd_status(s); chk("R8 write disable ignored while busy", 32'(s), 32'h1F);
      end
      wait_idle();
      rd_status(s); chk("R8 idle with latch cleared", 32'(s), 32'h1C);
    end
    for (int i = 0; i < MEMB; i++) model[i] = 8'hFF;
    qread(0, 8'h00, 1'b0, MEMB, "R7 R10 erased array via quad read");

    cmd1(8'h06); prog(24'h000105, 8, 1, 1'b0, 1'b1);
    rd_status(s); chk("R8 busy during program", 32'(s), 32'h1F);
    wait_idle();
    cmd1(8'h06); prog(24'h0001FC, 8, 2, 1'b0, 1'b1); wait_idle();
    cmd1(8'h06); prog(24'h000105, 8, 3, 1'b0, 1'b1); wait_idle();
    rd_status(s); chk("R8 latch cleared after program", 32'(s), 32'h1C);
    sread('h100, 256, "R5 R9 page program AND with wrap");

    prog(24'h000110, 4, 4, 1'b0, 1'b0);
    rd_status(s); chk("R4 program without latch leaves busy low", 32'(s), 32'h1C);
    erase(24'h000000, 3);
    rd_status(s); chk("R4 erase without latch leaves busy low", 32'(s), 32'h1C);
    sread('h100, 32, "R4 contents unchanged without latch");

    cmd1(8'h06); prog(24'h0002F0, 24, 5, 1'b1, 1'b1); wait_idle();
    qread('h200, 8'h00, 1'b0, 256, "R6 quad page program");

    cmd1(8'h06); erase(24'h000000, 2);
    rd_status(s); chk("R12 cut erase leaves busy low", 32'(s), 32'h1E);
    fstart(); sbyte(8'h02, r, o); send_addr(24'h000105);
    repeat (4) bit_x(4'h0, q, o);
    fend();
    rd_status(s); chk("R12 cut program leaves busy low", 32'(s), 32'h1E);
    cmd1(8'h04);
    sread('h100, 16, "R12 contents unchanged after cut commands");

    cmd1(8'h06); erase(24'h000345, 3); wait_idle();
    for (int i = 'h200; i < 'h400; i++) model[i] = 8'hFF;
    sread(0, MEMB, "R7 R9 sector erase with neighbours kept");

    cmd1(8'h06);
    fstart(); sbyte(8'h01, r, o); sbyte(8'h3C, r, o); fend();
    wait_idle();
    rd_status(s); chk("R14 status write stores bits 7:2", 32'(s), 32'h3C);
    fstart(); sbyte(8'h01, r, o); sbyte(8'hFC, r, o); fend();
    rd_status(s); chk("R4 status write without latch ignored", 32'(s), 32'h3C);

    qread('h105, 8'hA0, 1'b0, 4, "R11 quad read entering continuous mode");
    qread('h1FC, 8'h00, 1'b1, 8, "R11 continuous frame without opcode");
    rd_status(s); chk("R11 continuous mode left after other mode byte", 32'(s), 32'h3C);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R8 watchdog expired: got hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule